// File: doc/BRIEF.md
# Programmable Array Output Macrocell Bank

This block is the output stage of a sum-of-products programmable logic array. Each cell receives the OR-sum formed for it by the array, together with an output-enable product term of its own. A reset term, a preset term and the clock are shared by every cell. Two configuration bits per cell choose whether the sum passes through a D flip-flop or straight to the pin, and whether the pin is active-high or active-low. Each cell drives a three-state pin model, made of a drive value and an enable, and returns a feedback bit to the array.

The reset term clears the flip-flops at once, with no clock. The preset term sets them on the next rising edge. Both act on the stored bit, so the selected polarity still applies to what the pin shows afterwards. A synchronous power-on reset clears every flip-flop. A test load mode turns off all pin drivers, and on each clock edge copies the level present on each pin into that cell's flip-flop. This allows any state to be set up directly.

Top module: `plmc_cell`

## Requirements
- R1: Configuration per cell: `pol_sel_i` 1 means active-high and 0 means active-low; `path_sel_i` 0 means registered and 1 means combinational. Both bits at 0 (the blank default) give registered, active-low operation.
- R2: In registered mode the flip-flop takes `sum_i` on the rising clock edge. `pin_drive_o` is the stored bit when active-high and its inverse when active-low.
- R3: In registered mode `fb_o` carries the stored flip-flop bit, whatever the polarity.
- R4: In combinational mode `pin_drive_o` follows `sum_i` with no clock delay (inverted when active-low), and `fb_o` follows `pin_in_i`.
- R5: While `areset_term_i` is high, every flip-flop reads 0 immediately, with no clock edge needed.
- R6: When `spreset_term_i` is high at a rising edge, every flip-flop becomes 1.
- R7: If the reset term and the preset term are high together, the flip-flops clear to 0.
- R8: After preset or reset the pin level still follows the polarity: an active-low registered cell drives 0 after preset and 1 after reset.
- R9: `rst` high at a rising edge clears every flip-flop to 0.
- R10: While `preload_i` is high, `pin_oe_o` is all 0. Each rising edge loads every flip-flop from `pin_in_i`, and this takes priority over preset and over the sum.
- R11: Outside preload, `pin_oe_o` equals `oe_term_i`. A combinational cell with its enable held off acts as a plain input, and its feedback follows `pin_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| sum_i | input | NCELL | Sum-of-products result per cell |
| areset_term_i | input | 1 | Shared asynchronous clear term |
| spreset_term_i | input | 1 | Shared synchronous set term |
| oe_term_i | input | NCELL | Output-enable product term per cell |
| path_sel_i | input | NCELL | Mode bit per cell: 0 registered, 1 combinational |
| pol_sel_i | input | NCELL | Polarity bit per cell: 1 active-high, 0 active-low |
| preload_i | input | 1 | Test load mode |
| pin_in_i | input | NCELL | Level present on each pin |
| pin_drive_o | output | NCELL | Value driven to each pin |
| pin_oe_o | output | NCELL | Three-state enable per pin |
| fb_o | output | NCELL | Feedback to the array per cell |

## Verification
The bench runs the reset term and the preset term together, to catch a design that lets preset win or that makes reset wait for a clock. It also raises the reset term halfway through a cycle and looks at the pin at once. It sets active-low cells and then presets them, so a design that applies preset to the pin instead of the flip-flop shows a 1 where a 0 belongs. It mixes registered and combinational cells in one bank, so a feedback taken from the wrong source shows up. Test load runs with preset also high, and a design that lets preset win, or that keeps the drivers on, fails there.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

    typedef enum logic {
        PATH_REG  = 1'b0,
        PATH_COMB = 1'b1
    } path_e;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    typedef struct packed {
        path_e path;
        pol_e  pol;
    } cell_cfg_t;

    typedef enum logic [1:0] {
        SRC_SUM   = 2'd0,
        SRC_SET   = 2'd1,
        SRC_PIN   = 2'd2,
        SRC_CLEAR = 2'd3
    } flop_src_e;

    function automatic flop_src_e pick_src(input logic por, input logic load, input logic set);
        if (por)       return SRC_CLEAR;
        else if (load) return SRC_PIN;
        else if (set)  return SRC_SET;
        else           return SRC_SUM;
    endfunction

    function automatic logic apply_pol(input logic v, input pol_e p);
        return (p == POL_HIGH) ? v : ~v;
    endfunction

endpackage

// File: rtl/plmc_ctrl.sv
module plmc_ctrl
    import plmc_pkg::*;
(
    input  logic      rst,
    input  logic      preload_i,
    input  logic      spreset_i,
    output flop_src_e src_o
);
    always_comb begin
        src_o = pick_src(rst, preload_i, spreset_i);
    end
endmodule

// File: rtl/plmc_flop.sv
module plmc_flop
    import plmc_pkg::*;
(
    input  logic      clk,
    input  logic      clr_async_i,
    input  flop_src_e src_i,
    input  logic      sum_i,
    input  logic      pin_i,
    output logic      q_o
);
    always_ff @(posedge clk or posedge clr_async_i) begin
        if (clr_async_i) begin
            q_o <= 1'b0;
        end else begin
            unique case (src_i)
                SRC_CLEAR: q_o <= 1'b0;
                SRC_PIN:   q_o <= pin_i;
                SRC_SET:   q_o <= 1'b1;
                default:   q_o <= sum_i;
            endcase
        end
    end
endmodule

// File: rtl/plmc_outsel.sv
module plmc_outsel
    import plmc_pkg::*;
(
    input  cell_cfg_t cfg_i,
    input  logic      q_i,
    input  logic      sum_i,
    input  logic      pin_i,
    input  logic      oe_term_i,
    input  logic      preload_i,
    output logic      drive_o,
    output logic      oe_o,
    output logic      fb_o
);
    logic chosen;

    always_comb begin
        chosen  = (cfg_i.path == PATH_COMB) ? sum_i : q_i;
        drive_o = apply_pol(chosen, cfg_i.pol);
        oe_o    = oe_term_i & ~preload_i;
        fb_o    = (cfg_i.path == PATH_COMB) ? pin_i : q_i;
    end
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
    import plmc_pkg::*;
#(
    parameter int NCELL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCELL-1:0] sum_i,
    input  logic             areset_term_i,
    input  logic             spreset_term_i,
    input  logic [NCELL-1:0] oe_term_i,
    input  logic [NCELL-1:0] path_sel_i,
    input  logic [NCELL-1:0] pol_sel_i,
    input  logic             preload_i,
    input  logic [NCELL-1:0] pin_in_i,
    output logic [NCELL-1:0] pin_drive_o,
    output logic [NCELL-1:0] pin_oe_o,
    output logic [NCELL-1:0] fb_o
);
    flop_src_e        src;
    logic [NCELL-1:0] q_state;

    plmc_ctrl u_ctrl (
        .rst       (rst),
        .preload_i (preload_i),
        .spreset_i (spreset_term_i),
        .src_o     (src)
    );

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        cell_cfg_t cfg;

        always_comb begin
            cfg.path = path_e'(path_sel_i[g]);
            cfg.pol  = pol_e'(pol_sel_i[g]);
        end

        plmc_flop u_flop (
            .clk         (clk),
            .clr_async_i (areset_term_i),
            .src_i       (src),
            .sum_i       (sum_i[g]),
            .pin_i       (pin_in_i[g]),
            .q_o         (q_state[g])
        );

        plmc_outsel u_out (
            .cfg_i     (cfg),
            .q_i       (q_state[g]),
            .sum_i     (sum_i[g]),
            .pin_i     (pin_in_i[g]),
            .oe_term_i (oe_term_i[g]),
            .preload_i (preload_i),
            .drive_o   (pin_drive_o[g]),
            .oe_o      (pin_oe_o[g]),
            .fb_o      (fb_o[g])
        );
    end
endmodule

// File: rtl/plmc_chk.sv
module plmc_chk #(
    parameter int NCELL = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NCELL-1:0] sum_i,
    input logic             areset_term_i,
    input logic             spreset_term_i,
    input logic             preload_i,
    input logic [NCELL-1:0] pin_in_i,
    input logic [NCELL-1:0] path_sel_i,
    input logic [NCELL-1:0] pin_oe_o,
    input logic [NCELL-1:0] fb_o,
    input logic [NCELL-1:0] q_state
);
    a_r9_por_clear: assert property (@(posedge clk)
        rst |=> (q_state == '0));

    a_r5_async_clear: assert property (@(posedge clk) disable iff (rst)
        areset_term_i |-> (q_state == '0));

    a_r2_capture_sum: assert property (@(posedge clk) disable iff (rst)
        (!preload_i && !spreset_term_i && !areset_term_i)
        |=> (areset_term_i || q_state == $past(sum_i)));

    a_r6_preset_sets: assert property (@(posedge clk) disable iff (rst)
        (spreset_term_i && !preload_i && !areset_term_i)
        |=> (areset_term_i || q_state == '1));

    a_r10_load_from_pin: assert property (@(posedge clk) disable iff (rst)
        (preload_i && !areset_term_i)
        |=> (areset_term_i || q_state == $past(pin_in_i)));

    a_r10_drivers_off: assert property (@(posedge clk) disable iff (rst)
        preload_i |-> (pin_oe_o == '0));

    a_r4_comb_feedback: assert property (@(posedge clk) disable iff (rst)
        ((fb_o ^ pin_in_i) & path_sel_i) == '0);
endmodule

bind plmc_cell plmc_chk #(.NCELL(NCELL)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sum_i          (sum_i),
    .areset_term_i  (areset_term_i),
    .spreset_term_i (spreset_term_i),
    .preload_i      (preload_i),
    .pin_in_i       (pin_in_i),
    .path_sel_i     (path_sel_i),
    .pin_oe_o       (pin_oe_o),
    .fb_o           (fb_o),
    .q_state        (q_state)
);

// File: tb/plmc_cell_test.sv
module plmc_cell_test;
    localparam int N      = 4;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] sum, oe_term, path_sel, pol_sel, pin_in;
    logic         areset, spreset, preload;
    logic [N-1:0] pin_drive, pin_oe, fb;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model_q = '0;

    typedef struct {
        logic [N-1:0] drive;
        logic [N-1:0] oe;
        logic [N-1:0] fb;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    plmc_cell #(.NCELL(N)) uut (
        .clk(clk), .rst(rst), .sum_i(sum), .areset_term_i(areset),
        .spreset_term_i(spreset), .oe_term_i(oe_term), .path_sel_i(path_sel),
        .pol_sel_i(pol_sel), .preload_i(preload), .pin_in_i(pin_in),
        .pin_drive_o(pin_drive), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: set inputs at the falling edge and push what the pins show after the next rising edge.
    task automatic apply(input string tag, input logic r, input logic ar, input logic sp,
                         input logic pl, input logic [N-1:0] s, input logic [N-1:0] oe,
                         input logic [N-1:0] path, input logic [N-1:0] pol, input logic [N-1:0] pin);
        exp_t e;
        logic [N-1:0] nq;
        @(negedge clk);
        rst = r; areset = ar; spreset = sp; preload = pl;
        sum = s; oe_term = oe; path_sel = path; pol_sel = pol; pin_in = pin;
        if (r || ar)  nq = '0;
        else if (pl)  nq = pin;
        else if (sp)  nq = '1;
        else          nq = s;
        model_q = nq;
        e.drive = ((path & s) | (~path & nq)) ^ ~pol;
        e.oe    = oe & {N{~pl}};
        e.fb    = (path & pin) | (~path & nq);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " drive"}, pin_drive, e.drive);
            check({e.tag, " oe"},    pin_oe,    e.oe);
            check({e.tag, " fb"},    fb,        e.fb);
        end
    end

    initial begin
        #(PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; areset = 0; spreset = 0; preload = 0;
        sum = '0; oe_term = '0; path_sel = '0; pol_sel = '0; pin_in = '0;
        // R9 R1: reset, blank configuration is registered active-low
        apply("R9_R1 por blank", 1, 0, 0, 0, 4'b1111, 4'b1010, 4'b0000, 4'b0000, 4'b0000);
        // R2 R3 active-high registered
        apply("R2_R3 reg high", 0, 0, 0, 0, 4'b0101, 4'b1111, 4'b0000, 4'b1111, 4'b1100);
        apply("R2 reg low", 0, 0, 0, 0, 4'b0011, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
        apply("R3 reg mixed pol", 0, 0, 0, 0, 4'b1001, 4'b0110, 4'b0000, 4'b0101, 4'b1111);
        // R6 R8 preset with active-low pins: drive 0
        apply("R6_R8 preset", 0, 0, 1, 0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
        // R5 R8: reset term raised mid-cycle clears at once
        @(negedge clk);
        areset = 1;
        #1;
        model_q = '0;
        check("R5_R8 async clear drive", pin_drive, 4'b1111);
        check("R5 async clear fb", fb, 4'b0000);
        // R7 reset and preset together
        apply("R7 both terms", 0, 1, 1, 0, 4'b1111, 4'b1111, 4'b0000, 4'b1100, 4'b0000);
        apply("R2 after clear", 0, 0, 0, 0, 4'b0110, 4'b1111, 4'b0000, 4'b1100, 4'b0000);
        // R4 mixed combinational / registered bank
        apply("R4 comb mix", 0, 0, 0, 0, 4'b1100, 4'b1111, 4'b1010, 4'b0110, 4'b0101);
        apply("R4 comb mix b", 0, 0, 0, 0, 4'b0011, 4'b0101, 4'b1010, 4'b1001, 4'b1010);
        // R4: combinational output follows the sum with no edge
        @(negedge clk);
        path_sel = 4'b1111; pol_sel = 4'b1111; sum = 4'b1011;
        #1;
        check("R4 comb no delay", pin_drive, 4'b1011);
        // R10 preload with preset also high
        apply("R10 preload", 0, 0, 1, 1, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b1001);
        apply("R10 preload low pol", 0, 0, 1, 1, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0110);
        // R10: leaving preload, the loaded state holds until the next capture; R11 oe restored
        @(negedge clk);
        preload = 0; spreset = 0; pol_sel = 4'b1111; oe_term = 4'b0011;
        #1;
        check("R10 held load", pin_drive, 4'b0110);
        check("R11 oe restored", pin_oe, 4'b0011);
        // R11 dedicated-input use: enables off, combinational, feedback follows pin
        apply("R11 input use", 0, 0, 0, 0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b1101);
        apply("R11 input use b", 0, 0, 0, 0, 4'b1111, 4'b0000, 4'b1111, 4'b1111, 4'b0010);
        apply("R9 reset again", 1, 0, 0, 0, 4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b0000);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule